// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address stream for a short memory burst. A starting address is captured once. Each later advance step moves to the next beat without presenting a new address. The burst spans four beats by default, and the length is set by a parameter. Only the lowest address bits change during a burst. They walk through their group and wrap back inside it. All higher bits keep the value they had at the load.

The group of low bits can be walked in one of two orders, chosen by a strap input:
- **Linear order:** the beat index is added to the starting offset.
- **Interleaved order:** the beat index is XOR-ed into the starting offset.

A clock-enable input freezes the whole sequencer when it is low. The address and the burst position then stay as they are until it returns. The output address is a registered function of the loaded start and the beat count, so it is valid in the cycle after the capturing edge.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, `cur_addr` is all zeros.
- R2: At an edge where `clk_en`=1 and `advance`=0, `load_addr` is captured. From the next cycle `cur_addr` equals that value, and the burst restarts at beat 0. This also holds in the middle of a burst.
- R3: An advance step never changes `cur_addr` bits above bit 1. The low bits wrap inside their group and do not carry upward.
- R4: With `order_ilv`=0 (linear), beat k has low bits (start + k) mod 4. From start 01 the order is 01,10,11,00. From start 11 it is 11,00,01,10.
- R5: With `order_ilv`=1 (interleaved), beat k has low bits start XOR k. From start 01 the order is 01,00,11,10. From start 11 it is 11,10,01,00.
- R6: An advance step after the fourth beat returns the low bits to the starting offset, and the pattern repeats.
- R7: At an edge where `clk_en`=0, `cur_addr` and the beat position are held, whatever `advance` and `load_addr` are. The next advance step continues from the held beat.
- R8: During an advance step (`clk_en`=1, `advance`=1), the value on `load_addr` has no effect on `cur_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | Clock qualifier; low freezes all state |
| advance | input | 1 | 1 = step to the next beat, 0 = load a new start |
| load_addr | input | ADDR_W (17) | Starting address captured on a load |
| order_ilv | input | 1 | Static strap: 1 = interleaved order, 0 = linear order |
| cur_addr | output | ADDR_W (17) | Current burst address |

## Verification
A stall and a step or load request can arrive in the same cycle. This happens when `clk_en` is low while `advance` is high, or while `advance` is low with a new `load_addr`. The bench drives that case in the middle of every burst of the vector table, and once right after a fresh load. It then checks two things: the address did not move in the stalled cycle, and the following advance resumes at exactly the next beat of the stated order. A reload can also meet a burst in progress. This is provoked by loading after a partial burst, and it is judged by the address restarting at the new start and then stepping from beat 0.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

    // Walk order of the low address bits inside one burst group.
    typedef enum logic {
        ORDER_LINEAR      = 1'b0,
        ORDER_INTERLEAVED = 1'b1
    } order_e;

    // Per-edge action of the sequencer.
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_STEP = 2'd2
    } op_e;

endpackage

// File: rtl/bseq_decode.sv
module bseq_decode
    import bseq_pkg::*;
(
    input  logic clk_en,
    input  logic advance,
    output op_e  op
);

    // A frozen clock wins over both load and step requests.
    always_comb begin
        if (!clk_en) begin
            op = OP_HOLD;
        end else if (advance) begin
            op = OP_STEP;
        end else begin
            op = OP_LOAD;
        end
    end

endmodule

// File: rtl/bseq_state.sv
module bseq_state
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  op_e               op,
    input  logic [ADDR_W-1:0] load_addr,
    output logic [ADDR_W-1:0] base_q,
    output logic [BEAT_W-1:0] beat_q
);

    localparam logic [BEAT_W-1:0] BEAT_LAST = {BEAT_W{1'b1}};

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [BEAT_W-1:0] beat;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (op)
            OP_LOAD: begin
                st_d.base = load_addr;
                st_d.beat = '0;
            end
            OP_STEP: begin
                st_d.beat = st_q.beat + BEAT_W'(1);
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign base_q = st_q.base;
    assign beat_q = st_q.beat;

    // R2: a load restarts the burst position
    p_beat_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_LOAD) |=> (beat_q == '0));

    // R6: the last beat steps back to beat 0
    p_beat_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_STEP && beat_q == BEAT_LAST) |=> (beat_q == '0));

    // R7: a frozen edge keeps the burst position
    p_beat_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_HOLD) |=> $stable(beat_q) && $stable(base_q));

endmodule

// File: rtl/bseq_order.sv
module bseq_order
    import bseq_pkg::*;
#(
    parameter int BEAT_W = 2
) (
    input  logic [BEAT_W-1:0] start_low,
    input  logic [BEAT_W-1:0] beat,
    input  order_e            order,
    output logic [BEAT_W-1:0] low
);

    logic [BEAT_W-1:0] lin_low;
    logic [BEAT_W-1:0] ilv_low;

    // Linear: modulo add, the carry out of the group is dropped.
    assign lin_low = start_low + beat;

    // Interleaved: each bit is flipped by the matching beat bit.
    for (genvar i = 0; i < BEAT_W; i++) begin : g_ilv_bit
        assign ilv_low[i] = start_low[i] ^ beat[i];
    end

    always_comb begin
        low = (order == ORDER_INTERLEAVED) ? ilv_low : lin_low;
    end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              advance,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              order_ilv,
    output logic [ADDR_W-1:0] cur_addr
);

    op_e               op;
    logic [ADDR_W-1:0] base_q;
    logic [BEAT_W-1:0] beat_q;
    logic [BEAT_W-1:0] low;

    bseq_decode u_decode (
        .clk_en  (clk_en),
        .advance (advance),
        .op      (op)
    );

    bseq_state #(
        .ADDR_W (ADDR_W),
        .BEAT_W (BEAT_W)
    ) u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .load_addr (load_addr),
        .base_q    (base_q),
        .beat_q    (beat_q)
    );

    bseq_order #(
        .BEAT_W (BEAT_W)
    ) u_order (
        .start_low (base_q[BEAT_W-1:0]),
        .beat      (beat_q),
        .order     (order_e'(order_ilv)),
        .low       (low)
    );

    assign cur_addr = {base_q[ADDR_W-1:BEAT_W], low};

    // R2: the captured start shows up on the next cycle
    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !advance) |=> (cur_addr == $past(load_addr)));

    // R3: stepping leaves the upper address bits alone
    p_upper_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && advance) |=>
        (cur_addr[ADDR_W-1:BEAT_W] == $past(cur_addr[ADDR_W-1:BEAT_W])));

    // R4: linear order moves the low bits up by one, modulo the group
    p_lin_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && advance && !order_ilv) |=>
        (!$stable(order_ilv) ||
         cur_addr[BEAT_W-1:0] == $past(cur_addr[BEAT_W-1:0]) + BEAT_W'(1)));

    // R5: interleaved order flips bit 0 on every step
    p_ilv_lsb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && advance && order_ilv) |=>
        (!$stable(order_ilv) || cur_addr[0] != $past(cur_addr[0])));

    // R7: a frozen edge keeps the address
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en) |=> (!$stable(order_ilv) || $stable(cur_addr)));

endmodule

// File: tb/burst_addr_seq_tb.sv
`timescale 1ns/1ps
module burst_addr_seq_tb;

    localparam int AW = 17;
    localparam int BW = 2;

    typedef struct packed {
        logic          ilv;
        logic [AW-1:0] start;
        logic [7:0]    seq;   // beat0 in [7:6] .. beat3 in [1:0]
    } vec_t;

    // Expected orders written from R4 (linear) and R5 (interleaved).
    localparam vec_t VECS [8] = '{
        '{1'b0, 17'h0A5C0, 8'b00_01_10_11},
        '{1'b0, 17'h13371, 8'b01_10_11_00},
        '{1'b0, 17'h00F02, 8'b10_11_00_01},
        '{1'b0, 17'h1FFFF, 8'b11_00_01_10},
        '{1'b1, 17'h04440, 8'b00_01_10_11},
        '{1'b1, 17'h0BEE1, 8'b01_00_11_10},
        '{1'b1, 17'h12342, 8'b10_11_00_01},
        '{1'b1, 17'h1FFFF, 8'b11_10_01_00}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clk_en = 1'b0;
    logic          advance = 1'b0;
    logic [AW-1:0] load_addr = '0;
    logic          order_ilv = 1'b0;
    logic [AW-1:0] cur_addr;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW), .BEAT_W(BW)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_en    (clk_en),
        .advance   (advance),
        .load_addr (load_addr),
        .order_ilv (order_ilv),
        .cur_addr  (cur_addr)
    );

    task automatic check(input string tag, input logic [AW-1:0] exp);
        n_checks++;
        if (cur_addr !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, cur_addr, exp);
        end
    endtask

    // Set inputs, let one edge pass, sample 1 ns after it.
    task automatic cyc(input logic en, input logic adv, input logic [AW-1:0] la);
        clk_en = en;
        advance = adv;
        load_addr = la;
        @(posedge clk);
        #1;
    endtask

    initial begin
        logic [AW-1:0] exp;
        logic [7:0]    dseq;

        repeat (3) @(posedge clk);
        #1;
        check("R1 reset value", '0);
        rst_n = 1'b1;
        cyc(0, 0, 17'h15555);
        check("R1 idle after reset", '0);

        // Table walk: load, four steps with a stall after beat 1.
        for (int v = 0; v < 8; v++) begin
            order_ilv = VECS[v].ilv;
            cyc(1, 0, VECS[v].start);
            check($sformatf("R2 load vec%0d", v), VECS[v].start);
            exp = VECS[v].start;
            for (int k = 1; k <= 4; k++) begin
                if (k == 2) begin
                    cyc(0, 1, ~VECS[v].start);
                    check($sformatf("R7 stall vec%0d", v), exp);
                end
                // R8: load_addr carries garbage during every step.
                cyc(1, 1, ~VECS[v].start);
                exp = {VECS[v].start[AW-1:BW], VECS[v].seq[7-2*(k%4) -: 2]};
                check($sformatf("%s/R3/R8 vec%0d beat%0d",
                      (k == 4) ? "R6" : (VECS[v].ilv ? "R5" : "R4"), v, k), exp);
            end
        end

        // Stalled load request is ignored, then a stalled step.
        order_ilv = 1'b0;
        cyc(1, 0, 17'h00101);
        check("R2 load directed", 17'h00101);
        cyc(0, 0, 17'h1ABCD);
        check("R7 stalled load ignored", 17'h00101);
        cyc(0, 1, 17'h1ABCD);
        check("R7 stalled step ignored", 17'h00101);
        cyc(1, 1, 17'h1ABCD);
        check("R4 resume after stall", 17'h00102);

        // Reload mid-burst, then step across the group edge.
        cyc(1, 0, 17'h0FFF3);
        check("R2 mid-burst reload", 17'h0FFF3);
        cyc(1, 1, 17'h00000);
        check("R3 no carry linear", 17'h0FFF0);

        // Long interleaved run, start offset 10: 10,11,00,01 repeating.
        order_ilv = 1'b1;
        dseq = 8'b10_11_00_01;
        cyc(1, 0, 17'h00006);
        check("R2 load interleaved", 17'h00006);
        for (int k = 1; k <= 9; k++) begin
            cyc(1, 1, 17'h1FFFF);
            check($sformatf("R6 long run beat%0d", k), {15'h0001, dseq[7-2*(k%4) -: 2]});
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog (all requirements) actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule